// File: doc/BRIEF.md
# IR receive run-length sampler

The block is the receive front end of an infrared port. A demodulated IR line, low while carrier is present, is synchronised and sampled once every `SAMPLE_DIV` clock cycles while reception is enabled. Consecutive samples at the same level are counted and turned into run-length bytes. Bit 7 of each byte is the level (1 = pulse, 0 = space) and bits 6..0 are the run length in sample periods. The bytes are stored in a receive FIFO.

A host reads the FIFO through a byte-wide register port. A count register shows how many bytes the FIFO holds, and reading the data register removes the oldest byte. Runs of 127 periods or more are split into continuation bytes. A space that lasts the programmed idle limit closes the packet with an end marker. An 8-bit sticky status register with write-one-to-clear bits and an enable mask drives a single interrupt line. The four low status bits are fed from transmit-side event strobes.

Top module: `irrx_sampler`

## Requirements
- R1: `ir_in` passes through a two-flop synchroniser and is inverted: a low line is recorded as a pulse (bit 7 = 1), a high line as a space (bit 7 = 0).
- R2: While enabled, the line is sampled once every `SAMPLE_DIV` cycles. A level change emits one byte `{level, length}` for the finished run, where length is its sample count. Spaces before the first pulse of a packet are not recorded.
- R3: When a run reaches 127 samples, a byte with length 127 is emitted (0xFF for a pulse, 0x7F for a space) and the run continues from zero. A level change with zero samples counted since such a split emits nothing.
- R4: Let L be the 16-bit idle limit (register 5 = high byte, register 6 = low byte). On the L-th consecutive space sample (L >= 2), the byte 0x80 is emitted instead of the partial space run, status bit 5 (packet end) is set, and the sampler waits for the next pulse. L = 0 disables the timeout.
- R5: The registers are: 0 control (bit 0 receive enable), 1 status, 2 interrupt enable, 3 FIFO count, 4 FIFO data, 5/6 idle limit, 7 FIFO control. The FIFO holds `FIFO_DEPTH` bytes (32 by default) and returns them in order. Reading register 4 removes one byte, and reading it while empty returns 0. After reset every register reads 0.
- R6: A byte pushed into a full FIFO with no read in the same cycle is dropped and sets status bits 4 (overrun) and 7 (data ready).
- R7: Writing register 7 with bit 7 set empties the FIFO in one cycle. A byte emitted in that cycle is discarded.
- R8: Status bits are cleared by writing 1 to them. A bit set by an event in the same cycle stays set. Writing 0xFF with no events pending clears all bits.
- R9: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R10: While control bit 0 is 0, no bytes are emitted and the run state is discarded. After re-enabling, sampling begins a fresh packet.
- R11: Register 7 bits 5..0 hold a trigger level T. While T is nonzero and the FIFO count is at least T, status bit 6 is set every cycle.
- R12: Each cycle, `tx_evt[3:0]` is ORed into status bits 3..0.
- R13: Status bit 7 (data ready) is set whenever a byte is stored in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR line, low = carrier |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| tx_evt | input | 4 | Transmit-side event strobes into status bits 3..0 |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with `SAMPLE_DIV = 4` and `FIFO_DEPTH = 8`. The short sample period lets runs longer than 127 samples, idle limits and back-to-back packets fit in a few thousand cycles. The shallow FIFO lets a single train of alternating pulses and spaces overflow it, so the drop-on-full behaviour and the overrun and data-ready flags are reached without long stimulus. A behavioural model with a byte queue predicts `reg_rdata` and `irq` on every cycle. Directed reads compare the emitted bytes against hand-computed run lengths.

// File: rtl/irrx_pkg.sv
`timescale 1ns/1ps
package irrx_pkg;
  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_STATUS  = 3'd1;
  localparam logic [2:0] A_IEN     = 3'd2;
  localparam logic [2:0] A_COUNT   = 3'd3;
  localparam logic [2:0] A_DATA    = 3'd4;
  localparam logic [2:0] A_LIM_HI  = 3'd5;
  localparam logic [2:0] A_LIM_LO  = 3'd6;
  localparam logic [2:0] A_FIFOCTL = 3'd7;

  localparam int ST_READY = 7;
  localparam int ST_TRIG  = 6;
  localparam int ST_PEND  = 5;
  localparam int ST_OVR   = 4;

  localparam logic [7:0] END_MARK = 8'h80;
  localparam logic [6:0] LEN_MAX  = 7'h7F;

  // run-length byte: level in bit 7, sample count below it
  function automatic logic [7:0] run_byte(input logic lvl, input logic [6:0] len);
    return {lvl, len};
  endfunction

  // true when the coming space sample reaches the idle limit
  function automatic logic idle_expired(input logic [15:0] idle, input logic [15:0] lim);
    return (lim != 16'd0) && (({1'b0, idle} + 17'd1) >= {1'b0, lim});
  endfunction
endpackage

// File: rtl/irrx_run_encoder.sv
`timescale 1ns/1ps
module irrx_run_encoder import irrx_pkg::*; #(
  parameter int SAMPLE_DIV = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        ir_in,
  input  logic [15:0] idle_limit,
  output logic        push_o,
  output logic [7:0]  data_o
);
  localparam int PW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [1:0]    sync_q;
  logic [PW-1:0] presc_q;
  logic          active_q, cur_q;
  logic [6:0]    run_q;
  logic [15:0]   idle_q;

  logic          act_d, cur_d;
  logic [6:0]    run_d;
  logic [15:0]   idle_d;
  logic          pulse_now;
  logic          tick;

  assign pulse_now = ~sync_q[1];
  assign tick      = en && (presc_q == PW'(SAMPLE_DIV - 1));

  always_comb begin
    act_d  = active_q;
    cur_d  = cur_q;
    run_d  = run_q;
    idle_d = idle_q;
    push_o = 1'b0;
    data_o = 8'h00;
    if (!en) begin
      act_d  = 1'b0;
      cur_d  = 1'b0;
      run_d  = 7'd0;
      idle_d = 16'd0;
    end else if (tick) begin
      if (!active_q) begin
        if (pulse_now) begin
          act_d  = 1'b1;
          cur_d  = 1'b1;
          run_d  = 7'd1;
          idle_d = 16'd0;
        end
      end else if (pulse_now != cur_q) begin
        if (run_q != 7'd0) begin
          push_o = 1'b1;
          data_o = run_byte(cur_q, run_q);
        end
        cur_d  = pulse_now;
        run_d  = 7'd1;
        idle_d = pulse_now ? 16'd0 : 16'd1;
      end else if (!cur_q && idle_expired(idle_q, idle_limit)) begin
        push_o = 1'b1;
        data_o = END_MARK;
        act_d  = 1'b0;
        cur_d  = 1'b0;
        run_d  = 7'd0;
        idle_d = 16'd0;
      end else begin
        if (!cur_q) idle_d = idle_q + 16'd1;
        if ((run_q + 7'd1) == LEN_MAX) begin
          push_o = 1'b1;
          data_o = run_byte(cur_q, LEN_MAX);
          run_d  = 7'd0;
        end else begin
          run_d = run_q + 7'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      presc_q  <= '0;
      active_q <= 1'b0;
      cur_q    <= 1'b0;
      run_q    <= 7'd0;
      idle_q   <= 16'd0;
    end else begin
      sync_q   <= {sync_q[0], ir_in};
      if (!en || tick) presc_q <= '0;
      else             presc_q <= presc_q + PW'(1);
      active_q <= act_d;
      cur_q    <= cur_d;
      run_q    <= run_d;
      idle_q   <= idle_d;
    end
  end

  // R2: an emitted byte never carries a zero length except the end marker
  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (data_o[6:0] != 7'd0 || data_o == END_MARK));

  // R4: after an end marker the sampler waits for a new pulse
  p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && data_o == END_MARK) |=> !active_q);

  // R10: a disabled sampler emits nothing
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !push_o);
endmodule

// File: rtl/irrx_fifo.sv
`timescale 1ns/1ps
module irrx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          acc_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, full;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0) && !clr_i;
  assign acc_o   = push_i && !clr_i && (!full || do_pop);
  assign ovf_o   = push_i && !clr_i && full && !do_pop;
  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (acc_o) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (acc_o)  wp_q <= step(wp_q);
      if (do_pop) rp_q <= step(rp_q);
      cnt_q <= cnt_q + CW'(acc_o) - CW'(do_pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !pop_i && !clr_i) |=> (cnt_q == CW'(DEPTH)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/irrx_sampler.sv
`timescale 1ns/1ps
module irrx_sampler import irrx_pkg::*; #(
  parameter int SAMPLE_DIV = 10000,
  parameter int FIFO_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_in,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [3:0] tx_evt,
  output logic       irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic        en_q;
  logic [7:0]  ien_q, status_q;
  logic [15:0] limit_q;
  logic [5:0]  trig_q;

  logic        enc_push;
  logic [7:0]  enc_data;
  logic        fifo_clr, fifo_pop, fifo_acc, fifo_ovf;
  logic [7:0]  fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic [7:0]  cnt8;
  logic [7:0]  set_vec, w1c_mask;

  irrx_run_encoder #(.SAMPLE_DIV(SAMPLE_DIV)) u_enc (
    .clk(clk), .rst_n(rst_n), .en(en_q), .ir_in(ir_in),
    .idle_limit(limit_q), .push_o(enc_push), .data_o(enc_data));

  assign fifo_clr = reg_wr && (reg_addr == A_FIFOCTL) && reg_wdata[7];
  assign fifo_pop = reg_rd && (reg_addr == A_DATA);

  irrx_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr), .push_i(enc_push),
    .din_i(enc_data), .pop_i(fifo_pop), .dout_o(fifo_dout),
    .count_o(fifo_cnt), .acc_o(fifo_acc), .ovf_o(fifo_ovf));

  assign cnt8 = 8'(fifo_cnt);

  always_comb begin
    set_vec           = 8'h00;
    set_vec[3:0]      = tx_evt;
    set_vec[ST_TRIG]  = (trig_q != 6'd0) && (cnt8 >= {2'b00, trig_q});
    set_vec[ST_PEND]  = enc_push && (enc_data == END_MARK);
    set_vec[ST_OVR]   = fifo_ovf;
    set_vec[ST_READY] = fifo_acc || fifo_ovf;
  end

  assign w1c_mask = (reg_wr && reg_addr == A_STATUS) ? reg_wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ien_q    <= 8'h00;
      status_q <= 8'h00;
      limit_q  <= 16'd0;
      trig_q   <= 6'd0;
    end else begin
      status_q <= (status_q & ~w1c_mask) | set_vec;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:    en_q          <= reg_wdata[0];
          A_IEN:     ien_q         <= reg_wdata;
          A_LIM_HI:  limit_q[15:8] <= reg_wdata;
          A_LIM_LO:  limit_q[7:0]  <= reg_wdata;
          A_FIFOCTL: trig_q        <= reg_wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:    reg_rdata = {7'd0, en_q};
      A_STATUS:  reg_rdata = status_q;
      A_IEN:     reg_rdata = ien_q;
      A_COUNT:   reg_rdata = cnt8;
      A_DATA:    reg_rdata = (fifo_cnt == '0) ? 8'h00 : fifo_dout;
      A_LIM_HI:  reg_rdata = limit_q[15:8];
      A_LIM_LO:  reg_rdata = limit_q[7:0];
      A_FIFOCTL: reg_rdata = {2'b00, trig_q};
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign irq = |(status_q & ien_q);

  p_ovr_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_OVR]) |-> status_q[ST_READY]);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS) |=>
      ((status_q & $past(reg_wdata) & ~$past(set_vec)) == 8'h00));

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 8'h00) |-> !irq);

  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && fifo_cnt != '0 && !enc_push && !fifo_clr) |=>
      (fifo_cnt == $past(fifo_cnt) - CW'(1)));
endmodule

// File: tb/tb_irrx_sampler.sv
`timescale 1ns/1ps
module tb_irrx_sampler;
  localparam int DIV   = 4;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_in = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [3:0] tx_evt = 4'h0;
  logic [7:0] reg_rdata;
  logic       irq;

  always #2.5 clk = ~clk;

  irrx_sampler #(.SAMPLE_DIV(DIV), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_evt(tx_evt), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic       m_s1, m_s2, m_en, m_act, m_cur;
  int         m_presc, m_run, m_idle, m_lim, m_trig;
  logic [7:0] m_ien, m_status;
  logic [7:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_en = 0; m_act = 0; m_cur = 0;
      m_presc = 0; m_run = 0; m_idle = 0; m_lim = 0; m_trig = 0;
      m_ien = 0; m_status = 0; m_q.delete();
    end else begin
      logic p, tick, push, clr, pop;
      logic [7:0] pd, set, clrm;
      int cnt;
      p = ~m_s2;
      tick = m_en && (m_presc == DIV - 1);
      push = 0; pd = 0;
      if (tick) begin
        if (!m_act) begin
          if (p) begin m_act = 1; m_cur = 1; m_run = 1; m_idle = 0; end
        end else if (p != m_cur) begin
          if (m_run != 0) begin push = 1; pd = {m_cur, 7'(m_run)}; end
          m_cur = p; m_run = 1; m_idle = p ? 0 : 1;
        end else if (!m_cur && m_lim != 0 && m_idle + 1 >= m_lim) begin
          push = 1; pd = 8'h80; m_act = 0; m_cur = 0; m_run = 0; m_idle = 0;
        end else begin
          if (!m_cur) m_idle++;
          m_run++;
          if (m_run == 127) begin push = 1; pd = {m_cur, 7'h7F}; m_run = 0; end
        end
      end
      if (!m_en || m_presc == DIV - 1) m_presc = 0; else m_presc++;
      if (!m_en) begin m_act = 0; m_cur = 0; m_run = 0; m_idle = 0; end
      m_s2 = m_s1; m_s1 = ir_in;
      cnt = m_q.size();
      clr = reg_wr && reg_addr == 3'd7 && reg_wdata[7];
      pop = reg_rd && reg_addr == 3'd4 && cnt != 0;
      set = {4'h0, tx_evt};
      if (m_trig != 0 && cnt >= m_trig) set[6] = 1;
      if (push && pd == 8'h80) set[5] = 1;
      if (clr) m_q.delete();
      else begin
        if (pop) void'(m_q.pop_front());
        if (push) begin
          if (cnt < DEPTH || pop) begin m_q.push_back(pd); set[7] = 1; end
          else begin set[4] = 1; set[7] = 1; end
        end
      end
      clrm = (reg_wr && reg_addr == 3'd1) ? reg_wdata : 8'h00;
      m_status = (m_status & ~clrm) | set;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_en = reg_wdata[0];
          3'd2: m_ien = reg_wdata;
          3'd5: m_lim = (m_lim & 255) | (int'(reg_wdata) << 8);
          3'd6: m_lim = (m_lim & 32'hFF00) | int'(reg_wdata);
          3'd7: m_trig = int'(reg_wdata[5:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (reg_addr)
      3'd0: return {7'd0, m_en};
      3'd1: return m_status;
      3'd2: return m_ien;
      3'd3: return 8'(m_q.size());
      3'd4: return (m_q.size() == 0) ? 8'h00 : m_q[0];
      3'd5: return 8'(m_lim >> 8);
      3'd6: return 8'(m_lim);
      default: return 8'(m_trig);
    endcase
  endfunction

  // every-cycle comparison against the model (R5 read port, R9 interrupt)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 rdata vs model", int'(reg_rdata), int'(exp_rdata()));
      chk("R9 irq vs model", int'(irq), int'(|(m_status & m_ien)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic ir(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic expect_bytes(input string req, input logic [7:0] exp[$]);
    logic [7:0] v;
    rd(3'd3, v); chk({req, " count"}, int'(v), exp.size());
    foreach (exp[i]) begin
      rd(3'd4, v); chk({req, " byte"}, int'(v), int'(exp[i]));
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R5)
    rd(3'd1, v); chk("R5 reset status", int'(v), 0);
    rd(3'd3, v); chk("R5 reset count", int'(v), 0);
    rd(3'd0, v); chk("R5 reset ctrl", int'(v), 0);
    chk("R9 reset irq", int'(irq), 0);

    // R1 R2 R4 R13: basic packet with idle timeout 10
    wr(3'd5, 8'h00); wr(3'd6, 8'd10); wr(3'd0, 8'h01);
    ir(1, 6); ir(0, 5); ir(1, 3); ir(0, 2); ir(1, 12);
    rd(3'd1, v); chk("R4 R13 status pend+ready", int'(v), 8'hA0);
    expect_bytes("R1 R2 R4 packet", '{8'h85, 8'h03, 8'h82, 8'h80});
    rd(3'd4, v); chk("R5 empty read", int'(v), 0);
    wr(3'd1, 8'hFF);

    // R3: long runs split into continuation bytes
    ir(0, 130); ir(1, 2); ir(0, 127); ir(1, 10); ir(1, 2);
    expect_bytes("R3 split", '{8'hFF, 8'h83, 8'h02, 8'hFF, 8'h80});

    // R4 limit 0 disables timeout; R3 space split
    wr(3'd6, 8'h00); wr(3'd1, 8'hFF);
    ir(0, 1); ir(1, 130); ir(0, 1); ir(1, 3);
    wr(3'd0, 8'h00);
    // R10: disabled sampler ignores the line
    ir(0, 5); ir(1, 5); ir(0, 3);
    rd(3'd3, v); chk("R10 no bytes while disabled", int'(v), 4);
    expect_bytes("R4 R3 no timeout", '{8'h81, 8'h7F, 8'h03, 8'h81});
    // R10: fresh start on re-enable while line low
    wr(3'd0, 8'h01); ir(0, 5); ir(1, 3);
    rd(3'd3, v); chk("R10 one byte after restart", int'(v), 1);
    rd(3'd4, v);
    chk("R10 restart pulse flag", int'(v[7]), 1);
    chk("R10 restart length in 5..6", int'(v[6:0] >= 5 && v[6:0] <= 6), 1);
    wr(3'd0, 8'h00);

    // R6 overflow with limit 10
    wr(3'd6, 8'd10); wr(3'd1, 8'hFF); wr(3'd0, 8'h01);
    for (int i = 0; i < 6; i++) begin ir(0, 1); ir(1, 1); end
    ir(1, 12);
    rd(3'd3, v); chk("R6 count full", int'(v), DEPTH);
    rd(3'd1, v); chk("R6 status ovr+ready+pend", int'(v), 8'hB0);
    // R8 write-one-to-clear
    wr(3'd1, 8'h10);
    rd(3'd1, v); chk("R8 clear one bit", int'(v), 8'hA0);
    rd(3'd4, v); chk("R6 oldest kept", int'(v), 8'h81);
    // R7 FIFO clear
    wr(3'd7, 8'h80);
    rd(3'd3, v); chk("R7 count after clear", int'(v), 0);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); chk("R8 clear all", int'(v), 0);

    // R9 interrupt masking
    wr(3'd2, 8'h20);
    chk("R9 irq low with no status", int'(irq), 0);
    ir(0, 2); ir(1, 12);
    @(negedge clk); #1 chk("R9 irq on packet end", int'(irq), 1);
    wr(3'd2, 8'h01);
    #1 chk("R9 irq masked", int'(irq), 0);

    // R11 trigger level 2 (two bytes already held)
    wr(3'd7, 8'h02);
    rd(3'd1, v); chk("R11 trigger set", int'(v[6]), 1);
    wr(3'd1, 8'h40);
    rd(3'd1, v); chk("R11 trigger re-asserted", int'(v[6]), 1);
    wr(3'd7, 8'h82); wr(3'd1, 8'h40);
    rd(3'd1, v); chk("R11 trigger gone after clear", int'(v[6]), 0);

    // R12 transmit event strobes
    wr(3'd1, 8'hFF);
    @(negedge clk); tx_evt = 4'b0101;
    @(negedge clk); tx_evt = 4'b0000;
    rd(3'd1, v); chk("R12 event bits", int'(v[3:0]), 5);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule